// File: doc/BRIEF.md
# Sequential Integer Multiply and Divide Unit

This block carries out the eight integer multiply, divide and remainder operations of a 32-bit integer core. A decoder presents one operation at a time: a one-cycle start strobe, the register-form function fields, the two source operand values and the index of the destination register. The unit answers with a one-cycle completion strobe that carries the 32-bit result, the destination index and a write enable for the register file.

Multiplies finish on a short fixed path: the full product is formed in a single cycle and latched. Divides and remainders use a radix-2 restoring loop on operand magnitudes, one quotient bit per cycle at the default setting, and then fix the signs for the signed forms. The two architecturally defined corner cases, a zero divisor and signed overflow, are spotted when the operation is accepted and take the short path. No operation ever traps.

Top module: `mdu_seq`

## Requirements
- R1: A start strobe is accepted only when the unit is idle and `funct7_i` equals 7'b0000001; a start strobe with any other `funct7_i` value leaves `busy_o`, `done_o` and `wr_o` low.
- R2: With `funct3_i` = 3'b000 the result is the low 32 bits of the product of the two operands.
- R3: With `funct3_i` = 3'b001, 3'b010 and 3'b011 the result is the high 32 bits of the 64-bit product; 3'b001 treats both operands as signed, 3'b010 treats `rs1_i` as signed and `rs2_i` as unsigned, and 3'b011 treats both as unsigned.
- R4: With `funct3_i` = 3'b100 (signed) and 3'b101 (unsigned) the result is the quotient `rs1_i / rs2_i`; the signed quotient is rounded toward zero.
- R5: With `funct3_i` = 3'b110 (signed) and 3'b111 (unsigned) the result is the remainder; a nonzero signed remainder has the sign of `rs1_i`.
- R6: When `rs2_i` is zero, the divide forms (3'b100, 3'b101) return 32'hFFFF_FFFF and the remainder forms (3'b110, 3'b111) return `rs1_i` unchanged.
- R7: The signed divide of 32'h8000_0000 by 32'hFFFF_FFFF returns 32'h8000_0000 and the signed remainder of the same pair returns 0.
- R8: Counting the rising edge that accepts the start strobe as edge 1, `done_o` is high in the cycle after edge 2 for multiplies and for the R6/R7 cases, and in the cycle after edge 34 for all other divides and remainders.
- R9: `busy_o` is high from the cycle after acceptance until the cycle before `done_o`; `done_o` lasts exactly one cycle and is never high together with `busy_o`.
- R10: A start strobe while `busy_o` is high is ignored: the running operation's result and destination index are unchanged and no extra operation follows it.
- R11: With `done_o`, `rd_o` returns the accepted destination index and `wr_o` is high exactly when that index is nonzero.
- R12: After reset `busy_o`, `done_o` and `wr_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| funct7_i | input | 7 | Register-form function field; selects this unit when 7'b0000001 |
| funct3_i | input | 3 | Operation select: bit 2 picks divide/remainder, bits 1:0 the variant |
| rs1_i | input | 32 | First operand (multiplicand or dividend) |
| rs2_i | input | 32 | Second operand (multiplier or divisor) |
| rd_i | input | 5 | Destination register index |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 32 | Operation result, valid with `done_o` |
| rd_o | output | 5 | Destination index, valid with `done_o` |
| wr_o | output | 1 | Register write enable: `done_o` with a nonzero destination |

## Verification
The embedded properties assume that the reset is held for at least one clock edge before the first strobe and that the operands and `funct3_i` are stable in the cycle the strobe is sampled; the divider invariant also assumes a nonzero divisor on the loop path, which the unit guarantees by routing zero divisors to the short path. The bench drives every input at the falling edge, holds the strobe for exactly one cycle, and waits for completion before the next request, except in the deliberate overlap tests. Random operands are skewed so that zero divisors, the signed overflow pair, small divisors and negative values all appear often alongside fully random words.

// File: rtl/mdu_pkg.sv
// Shared definitions for the multiply/divide unit.
// Assumes: a register-form encoding where the function-7 field selects
// the unit and the function-3 field picks the operation.
package mdu_pkg;

    localparam int XLEN       = 32;
    localparam int REG_IDX_W  = 5;
    localparam logic [6:0] MULDIV_F7 = 7'b0000001;

    // Control states of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHORT = 2'd1,
        ST_LOOP  = 2'd2,
        ST_FIX   = 2'd3
    } mdu_state_e;

endpackage

// File: rtl/mdu_mul.sv
// Single-cycle multiplier producing the low or high half of a product.
// Assumes: op[1:0] = 00 low half, 01 signed x signed high,
// 10 signed x unsigned high, 11 unsigned x unsigned high.
// Purely combinational; the caller registers the result.
module mdu_mul #(
    parameter int W = 32
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);

    localparam int PW = 2 * W;

    logic          a_signed;
    logic          b_signed;
    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;

    // Choose operand extension from the variant bits.
    always_comb begin
        a_signed = (op == 2'b01) || (op == 2'b10);
        b_signed = (op == 2'b01);
        a_ext    = {{W{a_signed & a[W-1]}}, a};
        b_ext    = {{W{b_signed & b[W-1]}}, b};
    end

    // Product modulo 2^PW is exact for every variant.
    assign prod = a_ext * b_ext;

    // Select which half leaves the unit.
    always_comb begin
        if (op == 2'b00) res = prod[W-1:0];
        else             res = prod[PW-1:W];
    end

endmodule

// File: rtl/mdu_corner.sv
// Detects the divide corner cases that finish without iterating.
// Assumes: op[2] set means divide/remainder, op[1] set means remainder,
// op[0] clear means signed.  Combinational.
module mdu_corner #(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic zero_div;
    logic ovf;

    // Classify the operand pair.
    always_comb begin
        zero_div = (b == '0);
        ovf      = !op[0] && (a == MOST_NEG) && (b == ALL_ONES);
        hit      = op[2] && (zero_div || ovf);
    end

    // Defined result for each corner case.
    always_comb begin
        if (zero_div)   value = op[1] ? a : ALL_ONES;
        else if (ovf)   value = op[1] ? '0 : MOST_NEG;
        else            value = '0;
    end

endmodule

// File: rtl/mdu_div_step.sv
// One restoring-division step on unsigned magnitudes.
// Assumes: rem < dvs on entry and dvs is nonzero; then rem_n < dvs.
// The next dividend bit is taken from the top of quo and the new
// quotient bit is shifted in at the bottom.
module mdu_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_n,
    output logic [W-1:0] quo_n
);

    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    // Shift in a dividend bit, trial-subtract and restore on borrow.
    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - {1'b0, dvs};
        fits    = !diff[W];
        rem_n   = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_n   = {quo[W-2:0], fits};
    end

endmodule

// File: rtl/mdu_seq.sv
// Sequential multiply/divide unit.
// Accepts one operation at a time while idle.  Multiplies and divide
// corner cases take a two-edge short path; other divides run W/DIV_UNROLL
// restoring iterations on magnitudes and then a sign-fix cycle.
// Assumes: operands are stable in the cycle start_i is sampled; start_i
// while busy is dropped.  DIV_UNROLL must divide W.
module mdu_seq #(
    parameter int W          = mdu_pkg::XLEN,
    parameter int RW         = mdu_pkg::REG_IDX_W,
    parameter int DIV_UNROLL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [6:0]    funct7_i,
    input  logic [2:0]    funct3_i,
    input  logic [W-1:0]  rs1_i,
    input  logic [W-1:0]  rs2_i,
    input  logic [RW-1:0] rd_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  result_o,
    output logic [RW-1:0] rd_o,
    output logic          wr_o
);

    import mdu_pkg::*;

    localparam int STEPS = W / DIV_UNROLL;
    localparam int CW    = $clog2(STEPS + 1);

    mdu_state_e     state_q;
    logic           done_q;
    logic [W-1:0]   res_q;
    logic [RW-1:0]  rd_q;
    logic [W-1:0]   rem_q;
    logic [W-1:0]   quo_q;
    logic [W-1:0]   dvs_q;
    logic [CW-1:0]  cnt_q;
    logic           neg_quo_q;
    logic           neg_rem_q;
    logic           want_rem_q;

    logic           accept;
    logic           sgn_a;
    logic           sgn_b;
    logic [W-1:0]   mag_a;
    logic [W-1:0]   mag_b;
    logic [W-1:0]   mul_res;
    logic           corner_hit;
    logic [W-1:0]   corner_val;
    logic [W-1:0]   rem_c [DIV_UNROLL+1];
    logic [W-1:0]   quo_c [DIV_UNROLL+1];

    // Accept a request only when idle and the function-7 field matches.
    assign accept = start_i && (state_q == ST_IDLE) && (funct7_i == MULDIV_F7);

    // Operand signs and magnitudes for the divide loop.
    always_comb begin
        sgn_a = !funct3_i[0] && rs1_i[W-1];
        sgn_b = !funct3_i[0] && rs2_i[W-1];
        mag_a = sgn_a ? (~rs1_i + 1'b1) : rs1_i;
        mag_b = sgn_b ? (~rs2_i + 1'b1) : rs2_i;
    end

    mdu_mul #(.W(W)) u_mul (
        .op  (funct3_i[1:0]),
        .a   (rs1_i),
        .b   (rs2_i),
        .res (mul_res)
    );

    mdu_corner #(.W(W)) u_corner (
        .op    (funct3_i),
        .a     (rs1_i),
        .b     (rs2_i),
        .hit   (corner_hit),
        .value (corner_val)
    );

    assign rem_c[0] = rem_q;
    assign quo_c[0] = quo_q;

    // Chain of restoring steps executed in one cycle.
    for (genvar k = 0; k < DIV_UNROLL; k++) begin : g_step
        mdu_div_step #(.W(W)) u_step (
            .rem   (rem_c[k]),
            .quo   (quo_c[k]),
            .dvs   (dvs_q),
            .rem_n (rem_c[k+1]),
            .quo_n (quo_c[k+1])
        );
    end

    // Sequencer: accept, iterate, fix signs and raise the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b0;
            res_q      <= '0;
            rd_q       <= '0;
            rem_q      <= '0;
            quo_q      <= '0;
            dvs_q      <= '0;
            cnt_q      <= '0;
            neg_quo_q  <= 1'b0;
            neg_rem_q  <= 1'b0;
            want_rem_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        rd_q       <= rd_i;
                        want_rem_q <= funct3_i[1];
                        if (!funct3_i[2]) begin
                            res_q   <= mul_res;
                            state_q <= ST_SHORT;
                        end else if (corner_hit) begin
                            res_q   <= corner_val;
                            state_q <= ST_SHORT;
                        end else begin
                            rem_q     <= '0;
                            quo_q     <= mag_a;
                            dvs_q     <= mag_b;
                            cnt_q     <= CW'(STEPS);
                            neg_quo_q <= sgn_a ^ sgn_b;
                            neg_rem_q <= sgn_a;
                            state_q   <= ST_LOOP;
                        end
                    end
                end
                ST_SHORT: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_LOOP: begin
                    rem_q <= rem_c[DIV_UNROLL];
                    quo_q <= quo_c[DIV_UNROLL];
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    if (want_rem_q) res_q <= neg_rem_q ? (~rem_q + 1'b1) : rem_q;
                    else            res_q <= neg_quo_q ? (~quo_q + 1'b1) : quo_q;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the result side of the unit.
    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        done_o   = done_q;
        result_o = res_q;
        rd_o     = rd_q;
        wr_o     = done_q && (rd_q != '0);
    end

    // R1
    foreign_f7_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (funct7_i != MULDIV_F7)) |=> !busy_o);

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    busy_start_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(rd_o));

    // R6
    zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && funct3_i[2] && (rs2_i == '0)) |=> ##1
        (done_o && (result_o == ($past(funct3_i[1], 2) ? $past(rs1_i, 2) : {W{1'b1}}))));

    // R4
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP) |-> ((rem_q < dvs_q) && (cnt_q != '0)));

endmodule

// File: tb/sim_mdu_seq.sv
`timescale 1ns/1ps
module sim_mdu_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  f7 = 7'h01;
    logic [2:0]  f3 = 3'd0;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic [4:0]  rd_in = '0;
    logic        busy_o, done_o, wr_o;
    logic [31:0] result_o;
    logic [4:0]  rd_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mdu_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .funct7_i(f7),
        .funct3_i(f3), .rs1_i(a_in), .rs2_i(b_in), .rd_i(rd_in),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .rd_o(rd_o), .wr_o(wr_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit is_ovf(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        return op[2] && !op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        logic [63:0] sa = {{32{a[31]}}, a};
        logic [63:0] sb = {{32{b[31]}}, b};
        logic [63:0] za = {32'b0, a};
        logic [63:0] zb = {32'b0, b};
        case (op)
            3'd0: begin p = za * zb; return p[31:0]; end
            3'd1: begin p = sa * sb; return p[63:32]; end
            3'd2: begin p = sa * zb; return p[63:32]; end
            3'd3: begin p = za * zb; return p[63:32]; end
            3'd4: begin
                if (b == 0) return 32'hFFFF_FFFF;
                if (is_ovf(op, a, b)) return 32'h8000_0000;
                return $signed(a) / $signed(b);
            end
            3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
            3'd6: begin
                if (b == 0) return a;
                if (is_ovf(op, a, b)) return 32'h0;
                return $signed(a) % $signed(b);
            end
            default: return (b == 0) ? a : a % b;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        if (op == 3'd0) return "R2";
        if (!op[2]) return "R3";
        if (b == 0) return "R6";
        if (is_ovf(op, a, b)) return "R7";
        return op[1] ? "R5" : "R4";
    endfunction

    // One operation; poke issues a second start while the first is busy.
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] rd, input bit poke);
        int edges;
        int exp_edges;
        logic [31:0] exp;
        exp = model(op, a, b);
        exp_edges = (!op[2] || b == 0 || is_ovf(op, a, b)) ? 2 : 34;
        @(negedge clk);
        f7 = 7'h01; f3 = op; a_in = a; b_in = b; rd_in = rd; start = 1'b1;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy after accept", {31'b0, busy_o}, 32'd1);
        if (poke) begin
            start = 1'b1; a_in = ~a; b_in = 32'd3; rd_in = ~rd;
        end
        while (!done_o && edges < 80) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0;
        end
        chk("R8", "latency", edges, exp_edges);
        chk(req_of(op, a, b), $sformatf("op%0d result", op), result_o, exp);
        chk("R11", "rd", {27'b0, rd_o}, {27'b0, rd});
        chk("R11", "wr", {31'b0, wr_o}, {31'b0, (rd != 0)});
        chk("R9", "busy with done", {31'b0, busy_o}, 32'd0);
        @(negedge clk);
        chk("R9", "done width", {31'b0, done_o}, 32'd0);
        if (poke) chk("R10", "no follow-on op", {31'b0, busy_o}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7781));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12", "busy", {31'b0, busy_o}, 32'd0);
        chk("R12", "done", {31'b0, done_o}, 32'd0);
        chk("R12", "wr", {31'b0, wr_o}, 32'd0);
        chk("R12", "result", result_o, 32'd0);

        // R1: foreign funct7 ignored
        f7 = 7'h20; f3 = 3'd4; a_in = 32'd9; b_in = 32'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0; f7 = 7'h01;
        for (int i = 0; i < 3; i++) begin
            chk("R1", "busy", {31'b0, busy_o}, 32'd0);
            chk("R1", "done", {31'b0, done_o | wr_o}, 32'd0);
            @(negedge clk);
        end

        // Directed corner cases
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1, 0);   // R2
        run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd2, 0);   // R3
        run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 0);   // R3
        run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd4, 0);   // R3
        run_op(3'd1, 32'h8000_0000, 32'h8000_0000, 5'd5, 0);   // R3
        run_op(3'd4, 32'hFFFF_FFF9, 32'd2, 5'd6, 0);           // R4 -7/2
        run_op(3'd4, 32'd7, 32'hFFFF_FFFE, 5'd7, 0);           // R4 7/-2
        run_op(3'd6, 32'hFFFF_FFF9, 32'd2, 5'd8, 0);           // R5
        run_op(3'd6, 32'd7, 32'hFFFF_FFFE, 5'd9, 0);           // R5
        run_op(3'd5, 32'hFFFF_FFFF, 32'd1, 5'd10, 0);          // R4
        run_op(3'd7, 32'hFFFF_FFFF, 32'd16, 5'd11, 0);         // R5
        run_op(3'd4, 32'd123, 32'd0, 5'd12, 0);                // R6
        run_op(3'd5, 32'd123, 32'd0, 5'd13, 0);                // R6
        run_op(3'd6, 32'hDEAD_BEEF, 32'd0, 5'd14, 0);          // R6
        run_op(3'd7, 32'hDEAD_BEEF, 32'd0, 5'd15, 0);          // R6
        run_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 5'd16, 0);  // R7
        run_op(3'd6, 32'h8000_0000, 32'hFFFF_FFFF, 5'd17, 0);  // R7
        run_op(3'd5, 32'h8000_0000, 32'hFFFF_FFFF, 5'd18, 0);  // unsigned, full loop
        run_op(3'd0, 32'd6, 32'd7, 5'd0, 0);                   // R11 rd zero
        run_op(3'd4, 32'd1000, 32'd7, 5'd19, 1);               // R10
        run_op(3'd1, 32'd5, 32'd9, 5'd20, 1);                  // R10 short path

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  op = 3'($urandom % 8);
            logic [31:0] a  = $urandom;
            logic [31:0] b  = $urandom;
            int sel = $urandom % 8;
            if (sel == 0) b = 0;
            else if (sel == 1) begin a = 32'h8000_0000; b = 32'hFFFF_FFFF; end
            else if (sel == 2) b = 32'($urandom % 17);
            else if (sel == 3) a = -32'($urandom % 1000);
            run_op(op, a, b, 5'($urandom % 32), (n % 37) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule